// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block steers the four PCI interrupt request lines, together with zero, one or two motherboard interrupt lines, onto a 16-line ISA IRQ vector. Each source owns one configuration byte. That byte either names the IRQ number the source drives or switches the route off. When several enabled sources land on the same IRQ line, the line carries the OR of their levels.

Software programs the routes through a byte-wide configuration port. A write is taken on the clock edge while `cfg_we` is high. Read data is returned combinationally for whatever `cfg_addr` presents, with the unused bits of each route byte masked to zero.

The `NUM_MIRQ` parameter selects the variant:
- 2 gives the earliest part, which has two motherboard routes.
- 1 gives the later part, which has one motherboard route with a wider readback mask.
- 0 gives a part with no motherboard routes.

The routing path from the interrupt inputs to `irq_out` is purely combinational. Edge or level conversion and the interrupt controller lie outside this block.

Top module: `pci_irq_router`

## Requirements
- R1: While reset is asserted and after its release, every route byte holds its disabled reset value. PCI route bytes 0x60..0x63 read 0x80, and `irq_out` is 0 whatever the input levels are.
- R2: Bytes 0x60, 0x61, 0x62 and 0x63 route `pci_int[0]`, `pci_int[1]`, `pci_int[2]` and `pci_int[3]`. When bit 7 of a byte is 0, bits [3:0] give the target IRQ number n, and `irq_out[n]` follows the active-high source level.
- R3: When bit 7 of a route byte is 1, that route is disabled, and its source drives no `irq_out` bit.
- R4: A PCI route byte reads back as the stored value ANDed with 0x8F.
- R5: Each `irq_out` bit is the OR of all enabled, non-reserved sources whose target is that bit.
- R6: Targets 0, 1, 2, 8 and 13 are reserved. An enabled route to a reserved target drives no output.
- R7: When `NUM_MIRQ` >= 1, byte 0x70 routes `mb_irq[0]` with the same bit-7 disable and [3:0] target encoding, and it resets to 0xC0. When `NUM_MIRQ` = 0, byte 0x70 reads 0x00 and `mb_irq` has no effect.
- R8: Byte 0x70 reads back ANDed with 0xCF when `NUM_MIRQ` = 2, and ANDed with 0xEF when `NUM_MIRQ` = 1.
- R9: Byte 0x71 routes `mb_irq[1]` only when `NUM_MIRQ` = 2. In that case it resets to 0xC0 and reads back ANDed with 0xCF. Otherwise it reads 0x00, and `mb_irq[1]` is ignored.
- R10: Addresses that hold no route byte read 0x00, and writes to them change no route.
- R11: A route byte changes only on a rising clock edge with `cfg_we` high, and the new route applies from that edge on. `irq_out` follows input level changes in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Masked readback of the addressed byte; 0x00 if unmapped |
| pci_int | input | 4 | PCI interrupt levels, index 0 to 3 for INTA to INTD, active high |
| mb_irq | input | 2 | Motherboard interrupt levels, active high |
| irq_out | output | 16 | Steered ISA IRQ vector |

## Verification
The bench builds three copies of the router, with `NUM_MIRQ` set to 2, 1 and 0. All three share one configuration bus and one set of inputs, so every write reaches all three copies at once. The copy with two motherboard routes carries the main vector walk. The copy with one route brings the 0xEF readback mask within reach, along with the case where 0x71 is absent while `mb_irq[1]` toggles. The copy with no motherboard routes shows 0x70 reading zero while the motherboard lines are held high.

// File: rtl/pci_irq_router_pkg.sv
package pci_irq_router_pkg;
  typedef logic [7:0] cfg_byte_t;

  localparam int        OFF_BIT          = 7;
  localparam cfg_byte_t PCI_RST_VAL      = 8'h80;
  localparam cfg_byte_t MB_RST_VAL       = 8'hC0;
  localparam cfg_byte_t PCI_RD_MASK      = 8'h8F;
  localparam cfg_byte_t MB_RD_MASK_EARLY = 8'hCF;
  localparam cfg_byte_t MB_RD_MASK_LATE  = 8'hEF;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign rst_sync_no = sr_q[STAGES-1];
endmodule

// File: rtl/irq_route_reg.sv
module irq_route_reg
  import pci_irq_router_pkg::*;
#(
  parameter cfg_byte_t RESET_VAL = 8'h80
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  cfg_byte_t wr_data,
  output cfg_byte_t route_q
);
  cfg_byte_t route_d;

  always_comb begin
    route_d = route_q;
    if (wr_en) route_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) route_q <= RESET_VAL;
    else        route_q <= route_d;
  end
endmodule

// File: rtl/irq_route_decode.sv
module irq_route_decode #(
  parameter int                   IRQ_LINES     = 16,
  parameter logic [IRQ_LINES-1:0] RESERVED_MASK = 16'h2107,
  localparam int                  SEL_W         = $clog2(IRQ_LINES)
) (
  input  logic                 route_off,
  input  logic [SEL_W-1:0]     route_sel,
  input  logic                 level,
  output logic [IRQ_LINES-1:0] hit
);
  always_comb begin
    hit = '0;
    if (!route_off && level && !RESERVED_MASK[route_sel]) hit[route_sel] = 1'b1;
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pci_irq_router_pkg::*;
#(
  parameter int                   NUM_PCI       = 4,
  parameter int                   NUM_MIRQ      = 2,
  parameter int                   IRQ_LINES     = 16,
  parameter logic [7:0]           PCI_BASE      = 8'h60,
  parameter logic [7:0]           MB_BASE       = 8'h70,
  parameter logic [IRQ_LINES-1:0] RESERVED_MASK = 16'h2107
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_addr,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  input  logic [NUM_PCI-1:0]   pci_int,
  input  logic [1:0]           mb_irq,
  output logic [IRQ_LINES-1:0] irq_out
);
  localparam int NSRC  = NUM_PCI + NUM_MIRQ;
  localparam int SEL_W = $clog2(IRQ_LINES);

  logic                           rst_core_n;
  logic [NSRC-1:0]                src_lvl;
  cfg_byte_t [NSRC-1:0]           route_q;
  cfg_byte_t [NSRC-1:0]           rd_part;
  logic [NSRC-1:0][IRQ_LINES-1:0] hit;

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_core_n)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam bit        IS_PCI = (i < NUM_PCI);
    localparam cfg_byte_t ADDR   = IS_PCI ? 8'(int'(PCI_BASE) + i)
                                          : 8'(int'(MB_BASE) + i - NUM_PCI);
    localparam cfg_byte_t RST    = IS_PCI ? PCI_RST_VAL : MB_RST_VAL;
    localparam cfg_byte_t RDM    = IS_PCI ? PCI_RD_MASK :
                                   ((i == NUM_PCI) && (NUM_MIRQ == 1)) ? MB_RD_MASK_LATE
                                                                       : MB_RD_MASK_EARLY;
    logic hit_addr;
    assign hit_addr = (cfg_addr == ADDR);

    if (IS_PCI) begin : g_pci
      assign src_lvl[i] = pci_int[i];
    end else begin : g_mb
      assign src_lvl[i] = mb_irq[i-NUM_PCI];
    end

    irq_route_reg #(.RESET_VAL(RST)) u_reg (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .wr_en   (cfg_we && hit_addr),
      .wr_data (cfg_wdata),
      .route_q (route_q[i])
    );

    irq_route_decode #(
      .IRQ_LINES     (IRQ_LINES),
      .RESERVED_MASK (RESERVED_MASK)
    ) u_dec (
      .route_off (route_q[i][OFF_BIT]),
      .route_sel (route_q[i][SEL_W-1:0]),
      .level     (src_lvl[i]),
      .hit       (hit[i])
    );

    assign rd_part[i] = hit_addr ? (route_q[i] & RDM) : 8'h00;
  end

  always_comb begin
    irq_out   = '0;
    cfg_rdata = 8'h00;
    for (int i = 0; i < NSRC; i++) begin
      irq_out   = irq_out | hit[i];
      cfg_rdata = cfg_rdata | rd_part[i];
    end
  end
endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk #(
  parameter int                   NUM_PCI       = 4,
  parameter int                   NUM_MIRQ      = 2,
  parameter int                   IRQ_LINES     = 16,
  parameter logic [7:0]           PCI_BASE      = 8'h60,
  parameter logic [7:0]           MB_BASE       = 8'h70,
  parameter logic [IRQ_LINES-1:0] RESERVED_MASK = 16'h2107,
  localparam int                  NSRC          = NUM_PCI + NUM_MIRQ
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_we,
  input logic [7:0]            cfg_addr,
  input logic [7:0]            cfg_rdata,
  input logic [NUM_PCI-1:0]    pci_int,
  input logic [1:0]            mb_irq,
  input logic [IRQ_LINES-1:0]  irq_out,
  input logic [NSRC-1:0][7:0]  route_q
);
  logic all_off;
  logic mapped;
  logic quiet_in;

  always_comb begin
    all_off = 1'b1;
    for (int i = 0; i < NSRC; i++) all_off = all_off & route_q[i][7];
    mapped = ((int'(cfg_addr) >= int'(PCI_BASE)) && (int'(cfg_addr) < int'(PCI_BASE) + NUM_PCI)) ||
             ((int'(cfg_addr) >= int'(MB_BASE))  && (int'(cfg_addr) < int'(MB_BASE) + NUM_MIRQ));
    quiet_in = (pci_int == '0) &&
               ((NUM_MIRQ == 0) || ((NUM_MIRQ == 1) ? !mb_irq[0] : (mb_irq == 2'b00)));
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> irq_out == '0);

  p_inputs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_in |-> irq_out == '0);

  p_all_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    all_off |-> irq_out == '0);

  p_pci_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(cfg_addr) >= int'(PCI_BASE)) && (int'(cfg_addr) < int'(PCI_BASE) + NUM_PCI))
      |-> (cfg_rdata & 8'h70) == 8'h00);

  p_reserved_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & RESERVED_MASK) == '0);

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> cfg_rdata == 8'h00);

  p_hold_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(route_q));
endmodule

bind pci_irq_router pci_irq_router_chk #(
  .NUM_PCI       (NUM_PCI),
  .NUM_MIRQ      (NUM_MIRQ),
  .IRQ_LINES     (IRQ_LINES),
  .PCI_BASE      (PCI_BASE),
  .MB_BASE       (MB_BASE),
  .RESERVED_MASK (RESERVED_MASK)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .pci_int   (pci_int),
  .mb_irq    (mb_irq),
  .irq_out   (irq_out),
  .route_q   (route_q)
);

// File: tb/test_pci_irq_router.sv
module test_pci_irq_router;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [3:0]  pci_int;
  logic [1:0]  mb_irq;
  logic [7:0]  rd_m2, rd_m1, rd_m0;
  logic [15:0] irq_m2, irq_m1, irq_m0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  pci_irq_router #(.NUM_MIRQ(2)) i_pci_irq_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd_m2), .pci_int(pci_int), .mb_irq(mb_irq), .irq_out(irq_m2));
  pci_irq_router #(.NUM_MIRQ(1)) i_pci_irq_router_m1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd_m1), .pci_int(pci_int), .mb_irq(mb_irq), .irq_out(irq_m1));
  pci_irq_router #(.NUM_MIRQ(0)) i_pci_irq_router_m0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd_m0), .pci_int(pci_int), .mb_irq(mb_irq), .irq_out(irq_m0));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [3:0]  req;
    logic [7:0]  addr;
    logic [7:0]  data;
    logic [3:0]  pci;
    logic [1:0]  mb;
    logic [15:0] irq;
    logic [7:0]  rd;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{4'd2,  8'h60, 8'h05, 4'h1, 2'd0, 16'h0020, 8'h05},  // R2 INTA -> 5
    '{4'd2,  8'h61, 8'h0A, 4'h3, 2'd0, 16'h0420, 8'h0A},  // R2 INTB -> 10
    '{4'd5,  8'h62, 8'h05, 4'h4, 2'd0, 16'h0020, 8'h05},  // R5 INTC shares 5
    '{4'd3,  8'h63, 8'hFF, 4'hF, 2'd0, 16'h0420, 8'h8F},  // R3 R4 INTD off, OR of 5
    '{4'd2,  8'h63, 8'h0F, 4'h8, 2'd0, 16'h8000, 8'h0F},  // R2 INTD -> 15
    '{4'd6,  8'h60, 8'h08, 4'h1, 2'd0, 16'h0000, 8'h08},  // R6 reserved 8
    '{4'd4,  8'h60, 8'h7D, 4'h1, 2'd0, 16'h0000, 8'h0D},  // R4 mask, R6 reserved 13
    '{4'd7,  8'h70, 8'h03, 4'h0, 2'd1, 16'h0008, 8'h03},  // R7 MIRQ0 -> 3
    '{4'd9,  8'h71, 8'hE4, 4'h0, 2'd2, 16'h0000, 8'hC4},  // R9 MIRQ1 off
    '{4'd9,  8'h71, 8'h34, 4'h0, 2'd3, 16'h0018, 8'h04},  // R9 MIRQ1 -> 4
    '{4'd8,  8'h70, 8'h39, 4'h2, 2'd1, 16'h0600, 8'h09},  // R8 mask 0xCF, -> 9
    '{4'd10, 8'h40, 8'hAA, 4'hF, 2'd3, 16'h8630, 8'h00},  // R10 unmapped
    '{4'd10, 8'h72, 8'h07, 4'hF, 2'd3, 16'h8630, 8'h00},  // R10 unmapped
    '{4'd6,  8'h60, 8'h01, 4'h1, 2'd0, 16'h0000, 8'h01},  // R6 reserved 1
    '{4'd6,  8'h60, 8'h02, 4'h1, 2'd0, 16'h0000, 8'h02},  // R6 reserved 2
    '{4'd2,  8'h60, 8'h0E, 4'h1, 2'd0, 16'h4000, 8'h0E}   // R2 INTA -> 14
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr  = a;
    cfg_wdata = d;
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 8'h00; cfg_wdata = 8'h00;
    pci_int = 4'hF; mb_irq = 2'b11;
    #1;
    check("R1 irq in reset", irq_m2, 16'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R7 R9 reset state
    check("R1 irq after reset m2", irq_m2, 16'h0);
    check("R1 irq after reset m1", irq_m1, 16'h0);
    check("R7 irq after reset m0", irq_m0, 16'h0);
    for (int a = 8'h60; a <= 8'h63; a++) begin
      cfg_addr = 8'(a);
      #1;
      check("R1 pci byte reset", {8'h0, rd_m2}, 16'h0080);
    end
    cfg_addr = 8'h70; #1;
    check("R7 mirq0 reset m2", {8'h0, rd_m2}, 16'h00C0);
    check("R7 mirq0 reset m1", {8'h0, rd_m1}, 16'h00C0);
    check("R7 mirq0 absent m0", {8'h0, rd_m0}, 16'h0000);
    cfg_addr = 8'h71; #1;
    check("R9 mirq1 reset m2", {8'h0, rd_m2}, 16'h00C0);

    // vector walk on the NUM_MIRQ=2 copy
    for (int v = 0; v < NVEC; v++) begin
      cfg_write(VEC[v].addr, VEC[v].data);
      pci_int = VEC[v].pci;
      mb_irq  = VEC[v].mb;
      #1;
      check($sformatf("R%0d vec %0d irq_out", VEC[v].req, v), irq_m2, VEC[v].irq);
      check($sformatf("R%0d vec %0d readback", VEC[v].req, v), {8'h0, rd_m2}, {8'h0, VEC[v].rd});
    end

    // R7 R8 R9 variants
    @(negedge clk);
    pci_int = 4'h0; mb_irq = 2'b11; cfg_addr = 8'h70;
    #1;
    check("R9 both mirq m2", irq_m2, 16'h0210);
    check("R9 mirq1 ignored m1", irq_m1, 16'h0200);
    check("R7 no mirq m0", irq_m0, 16'h0000);
    check("R8 mask 0xCF m2", {8'h0, rd_m2}, 16'h0009);
    check("R8 mask 0xEF m1", {8'h0, rd_m1}, 16'h0029);
    check("R7 0x70 reads 0 m0", {8'h0, rd_m0}, 16'h0000);
    cfg_addr = 8'h71; #1;
    check("R9 0x71 absent m1", {8'h0, rd_m1}, 16'h0000);
    check("R9 0x71 present m2", {8'h0, rd_m2}, 16'h0004);

    // R11 write takes effect at the edge
    @(negedge clk);
    mb_irq = 2'b00; pci_int = 4'h2;
    cfg_addr = 8'h61; cfg_wdata = 8'h0C; cfg_we = 1'b1;
    #1;
    check("R11 before edge", irq_m2, 16'h0400);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check("R11 after edge", irq_m2, 16'h1000);
    pci_int = 4'h0; #1;
    check("R11 input same cycle", irq_m2, 16'h0000);

    // R10 R11 no write without enable
    @(negedge clk);
    cfg_addr = 8'h61; cfg_wdata = 8'h80; cfg_we = 1'b0;
    @(negedge clk);
    pci_int = 4'h2; #1;
    check("R11 no write route", irq_m2, 16'h1000);
    check("R11 no write readback", {8'h0, rd_m2}, 16'h000C);

    // R1 reset during operation
    rst_n = 1'b0; #1;
    check("R1 irq mid reset", irq_m2, 16'h0000);
    check("R1 byte mid reset", {8'h0, rd_m2}, 16'h0080);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule